// File: doc/BRIEF.md
# Two-Level Debug Breakpoint Trigger

This unit watches two streams from a processor core: the instruction address, with a valid strobe, and the operand bus address and data, with a valid strobe of its own. It compares them against programmed reference values and raises a one-cycle breakpoint pulse when a chosen condition holds. There is one program-counter comparator and two address comparators. Each address comparator can be qualified by its own masked data comparator.

A four-bit selector picks one of a fixed list of legal term combinations. In one-level mode the pulse fires when any selected term hits. In two-level mode a first term must hit to arm the unit. A later hit of a second, different term then fires the pulse and disarms the unit. A re-arm input and a configuration-write strobe both clear the armed state. The `armed` output exposes that state.

Top module: `bkpt_trigger`

## Requirements
- R1: While `rst` is high at a clock edge, `trig` and `armed` are 0 after that edge.
- R2: One-level selector codes fire `trig` in the cycle after the edge at which any selected term hits. The codes are 1 = PC, 2 = PC or A0, 3 = PC or A0 or A1, 4 = A0, 5 = A0 or A1, and 6 = A1. Under these codes `armed` stays 0.
- R3: Two-level codes are 8 = PC then A0, 9 = PC then (A0 or A1), 10 = PC then A1, 11 = A0 then A1, 12 = A1 then A0, 13 = A0 then PC, and 14 = A1 then PC. A hit of the first term while unarmed sets `armed`. While armed, a hit of the second term pulses `trig` for one cycle and clears `armed` at the same edge. `trig` and `armed` are never high together.
- R4: In two-level mode, if the first and second terms both hit in one cycle while the unit is unarmed, the unit only arms. Firing needs a second-term hit in a later cycle.
- R5: Address mode 2 (inside) matches when lo <= addr <= hi. Both bounds are included.
- R6: Address mode 1 (equal) matches only when the bus address equals the low-bound value.
- R7: Address mode 3 (outside) matches when addr < lo or addr > hi. An address equal to either bound does not match.
- R8: Address mode 0 never matches. An address term needs `bus_valid`, and the PC term needs `pc_valid` and `pc == pc_ref`.
- R9: When a comparator's data enable is 1, its term also needs `bus_data` to equal its data value on every bit whose mask bit is 0. Bits whose mask bit is 1 are ignored. The data compare uses the same cycle's bus data.
- R10: Selector codes 0, 7 and 15 never raise `trig` and never set `armed`.
- R11: A cycle with `rearm` or `cfg_wr` high clears `armed` and produces no `trig` at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sel | input | 4 | Term combination selector |
| cfg_wr | input | 1 | Configuration write strobe; clears the armed state |
| rearm | input | 1 | Clears the armed state |
| pc_ref | input | AW | PC breakpoint value |
| pc_valid | input | 1 | PC stream valid |
| pc | input | AW | Instruction address |
| a0_mode | input | 2 | Comparator 0 mode: 0 off, 1 equal, 2 inside, 3 outside |
| a0_lo | input | AW | Comparator 0 low bound or equal value |
| a0_hi | input | AW | Comparator 0 high bound |
| a0_den | input | 1 | Comparator 0 data qualifier enable |
| a0_dval | input | DW | Comparator 0 data value |
| a0_dmask | input | DW | Comparator 0 ignore mask (1 = ignore bit) |
| a1_mode | input | 2 | Comparator 1 mode |
| a1_lo | input | AW | Comparator 1 low bound or equal value |
| a1_hi | input | AW | Comparator 1 high bound |
| a1_den | input | 1 | Comparator 1 data qualifier enable |
| a1_dval | input | DW | Comparator 1 data value |
| a1_dmask | input | DW | Comparator 1 ignore mask |
| bus_valid | input | 1 | Operand bus valid |
| bus_addr | input | AW | Operand bus address |
| bus_data | input | DW | Operand bus data |
| trig | output | 1 | Breakpoint pulse |
| armed | output | 1 | Level one satisfied, waiting for level two |

## Verification
The assertions check, on every cycle, the properties that need no history of the stream:
- a disabled or idle comparator never hits;
- the inside mode hits on its bounds and the outside mode does not;
- illegal and one-level codes never leave the unit armed;
- a clear stops any pulse at the next edge;
- an unarmed two-level unit cannot fire;
- `trig` and `armed` are never high together.

Only the bench's scenarios can show the rest. That covers the right pairing of first and second terms for each ordering, firing on the later event when both terms hit together, and the data mask under varied values. Random streams are compared against a reference model for this.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

    typedef enum logic [1:0] {
        AM_OFF = 2'd0,
        AM_EQ  = 2'd1,
        AM_IN  = 2'd2,
        AM_OUT = 2'd3
    } amode_e;

    // one bit per base term
    typedef struct packed {
        logic a1;
        logic a0;
        logic pc;
    } terms_t;

    typedef struct packed {
        logic   legal;
        logic   two;
        terms_t first;
        terms_t second;
    } plan_t;

    localparam terms_t T_NONE = '{a1: 1'b0, a0: 1'b0, pc: 1'b0};
    localparam terms_t T_PC   = '{a1: 1'b0, a0: 1'b0, pc: 1'b1};
    localparam terms_t T_A0   = '{a1: 1'b0, a0: 1'b1, pc: 1'b0};
    localparam terms_t T_A1   = '{a1: 1'b1, a0: 1'b0, pc: 1'b0};

    function automatic plan_t decode_sel(input logic [3:0] sel);
        plan_t p;
        p.legal  = 1'b1;
        p.two    = 1'b0;
        p.first  = T_NONE;
        p.second = T_NONE;
        case (sel)
            4'd1:  p.first = T_PC;
            4'd2:  p.first = T_PC | T_A0;
            4'd3:  p.first = T_PC | T_A0 | T_A1;
            4'd4:  p.first = T_A0;
            4'd5:  p.first = T_A0 | T_A1;
            4'd6:  p.first = T_A1;
            4'd8:  begin p.two = 1'b1; p.first = T_PC; p.second = T_A0;        end
            4'd9:  begin p.two = 1'b1; p.first = T_PC; p.second = T_A0 | T_A1; end
            4'd10: begin p.two = 1'b1; p.first = T_PC; p.second = T_A1;        end
            4'd11: begin p.two = 1'b1; p.first = T_A0; p.second = T_A1;        end
            4'd12: begin p.two = 1'b1; p.first = T_A1; p.second = T_A0;        end
            4'd13: begin p.two = 1'b1; p.first = T_A0; p.second = T_PC;        end
            4'd14: begin p.two = 1'b1; p.first = T_A1; p.second = T_PC;        end
            default: p.legal = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/bkpt_addr_term.sv
module bkpt_addr_term
    import bkpt_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] lo,
    input  logic [AW-1:0] hi,
    input  logic          den,
    input  logic [DW-1:0] dval,
    input  logic [DW-1:0] dmask,
    input  logic          valid,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] data,
    output logic          hit
);

    amode_e mode_e;
    logic   below_lo;
    logic   above_hi;
    logic   addr_ok;
    logic   data_ok;

    always_comb begin
        mode_e   = amode_e'(mode);
        below_lo = addr < lo;
        above_hi = addr > hi;
        case (mode_e)
            AM_EQ:   addr_ok = (addr == lo);
            AM_IN:   addr_ok = !below_lo && !above_hi;
            AM_OUT:  addr_ok = below_lo || above_hi;
            default: addr_ok = 1'b0;
        endcase
        data_ok = !den || (((data ^ dval) & ~dmask) == '0);
        hit     = valid && addr_ok && data_ok;
    end

    // R8
    mode_off_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0) |-> !hit);
    // R8
    idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
        !valid |-> !hit);
    // R5
    range_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && mode == 2'd2 && !den && lo <= hi && (addr == lo || addr == hi)) |-> hit);
    // R7
    outside_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3 && (addr == lo || addr == hi)) |-> !hit);

endmodule

// File: rtl/bkpt_seq.sv
module bkpt_seq
    import bkpt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] sel,
    input  logic       cfg_wr,
    input  logic       rearm,
    input  terms_t     terms,
    output logic       trig,
    output logic       armed
);

    plan_t p;
    logic  hit_first;
    logic  hit_second;
    logic  clr;
    logic  trig_d;
    logic  armed_d;
    logic  trig_q;
    logic  armed_q;

    always_comb begin
        p          = decode_sel(sel);
        hit_first  = |(p.first & terms);
        hit_second = |(p.second & terms);
        clr        = rearm || cfg_wr;
        trig_d     = 1'b0;
        armed_d    = armed_q;
        if (clr || !p.legal) begin
            armed_d = 1'b0;
        end else if (!p.two) begin
            trig_d  = hit_first;
            armed_d = 1'b0;
        end else if (armed_q) begin
            if (hit_second) begin
                trig_d  = 1'b1;
                armed_d = 1'b0;
            end
        end else if (hit_first) begin
            armed_d = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q  <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            trig_q  <= trig_d;
            armed_q <= armed_d;
        end
    end

    assign trig  = trig_q;
    assign armed = armed_q;

    // R3
    fire_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        trig_q |-> !armed_q);
    // R11
    clear_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rearm || cfg_wr) |=> (!armed_q && !trig_q));
    // R10
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !decode_sel(sel).legal |=> (!armed_q && !trig_q));
    // R2
    one_level_noarm_chk: assert property (@(posedge clk) disable iff (rst)
        !decode_sel(sel).two |=> !armed_q);
    // R4
    arm_before_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (decode_sel(sel).two && !armed_q) |=> !trig_q);

endmodule

// File: rtl/bkpt_trigger.sv
module bkpt_trigger
    import bkpt_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    cfg_sel,
    input  logic          cfg_wr,
    input  logic          rearm,
    input  logic [AW-1:0] pc_ref,
    input  logic          pc_valid,
    input  logic [AW-1:0] pc,
    input  logic [1:0]    a0_mode,
    input  logic [AW-1:0] a0_lo,
    input  logic [AW-1:0] a0_hi,
    input  logic          a0_den,
    input  logic [DW-1:0] a0_dval,
    input  logic [DW-1:0] a0_dmask,
    input  logic [1:0]    a1_mode,
    input  logic [AW-1:0] a1_lo,
    input  logic [AW-1:0] a1_hi,
    input  logic          a1_den,
    input  logic [DW-1:0] a1_dval,
    input  logic [DW-1:0] a1_dmask,
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    output logic          trig,
    output logic          armed
);

    localparam int NCMP = 2;

    logic [1:0]    mode_a  [NCMP];
    logic [AW-1:0] lo_a    [NCMP];
    logic [AW-1:0] hi_a    [NCMP];
    logic          den_a   [NCMP];
    logic [DW-1:0] dval_a  [NCMP];
    logic [DW-1:0] dmask_a [NCMP];
    logic [NCMP-1:0] addr_hit;
    terms_t        terms;

    assign mode_a[0]  = a0_mode;
    assign lo_a[0]    = a0_lo;
    assign hi_a[0]    = a0_hi;
    assign den_a[0]   = a0_den;
    assign dval_a[0]  = a0_dval;
    assign dmask_a[0] = a0_dmask;
    assign mode_a[1]  = a1_mode;
    assign lo_a[1]    = a1_lo;
    assign hi_a[1]    = a1_hi;
    assign den_a[1]   = a1_den;
    assign dval_a[1]  = a1_dval;
    assign dmask_a[1] = a1_dmask;

    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
        bkpt_addr_term #(.AW(AW), .DW(DW)) u_term (
            .clk   (clk),
            .rst   (rst),
            .mode  (mode_a[i]),
            .lo    (lo_a[i]),
            .hi    (hi_a[i]),
            .den   (den_a[i]),
            .dval  (dval_a[i]),
            .dmask (dmask_a[i]),
            .valid (bus_valid),
            .addr  (bus_addr),
            .data  (bus_data),
            .hit   (addr_hit[i])
        );
    end

    always_comb begin
        terms.pc = pc_valid && (pc == pc_ref);
        terms.a0 = addr_hit[0];
        terms.a1 = addr_hit[1];
    end

    bkpt_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .sel    (cfg_sel),
        .cfg_wr (cfg_wr),
        .rearm  (rearm),
        .terms  (terms),
        .trig   (trig),
        .armed  (armed)
    );

    // R8
    pc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !pc_valid |-> !terms.pc);

endmodule

// File: tb/bkpt_trigger_bench.sv
module bkpt_trigger_bench;

    localparam int AW = 32;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic [3:0]    cfg_sel;
    logic          cfg_wr, rearm;
    logic [AW-1:0] pc_ref, pc;
    logic          pc_valid;
    logic [1:0]    a0_mode, a1_mode;
    logic [AW-1:0] a0_lo, a0_hi, a1_lo, a1_hi;
    logic          a0_den, a1_den;
    logic [DW-1:0] a0_dval, a0_dmask, a1_dval, a1_dmask;
    logic          bus_valid;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_data;
    logic          trig, armed;

    int n_tests = 0;
    int n_fail  = 0;
    bit m_trig  = 1'b0;
    bit m_armed = 1'b0;

    always #10 clk = ~clk;

    bkpt_trigger #(.AW(AW), .DW(DW)) u_bkpt_trigger (
        .clk(clk), .rst(rst), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .rearm(rearm),
        .pc_ref(pc_ref), .pc_valid(pc_valid), .pc(pc),
        .a0_mode(a0_mode), .a0_lo(a0_lo), .a0_hi(a0_hi), .a0_den(a0_den),
        .a0_dval(a0_dval), .a0_dmask(a0_dmask),
        .a1_mode(a1_mode), .a1_lo(a1_lo), .a1_hi(a1_hi), .a1_den(a1_den),
        .a1_dval(a1_dval), .a1_dmask(a1_dmask),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
        .trig(trig), .armed(armed)
    );

    function automatic bit f_addr(input logic [1:0] mode, input logic [AW-1:0] lo,
                                  input logic [AW-1:0] hi, input logic den,
                                  input logic [DW-1:0] dv, input logic [DW-1:0] dm);
        bit a;
        case (mode)
            2'd1: a = (bus_addr == lo);
            2'd2: a = (bus_addr >= lo) && (bus_addr <= hi);
            2'd3: a = (bus_addr < lo) || (bus_addr > hi);
            default: a = 1'b0;
        endcase
        if (den && (((bus_data ^ dv) & ~dm) != '0)) a = 1'b0;
        return bus_valid && a;
    endfunction

    // returns {pc,a0,a1} masks for level one and level two
    function automatic bit [5:0] f_sets(input logic [3:0] s);
        case (s)
            4'd1:  return 6'b100_000;
            4'd2:  return 6'b110_000;
            4'd3:  return 6'b111_000;
            4'd4:  return 6'b010_000;
            4'd5:  return 6'b011_000;
            4'd6:  return 6'b001_000;
            4'd8:  return 6'b100_010;
            4'd9:  return 6'b100_011;
            4'd10: return 6'b100_001;
            4'd11: return 6'b010_001;
            4'd12: return 6'b001_010;
            4'd13: return 6'b010_100;
            4'd14: return 6'b001_100;
            default: return 6'b000_000;
        endcase
    endfunction

    function automatic string f_tag(input logic [3:0] s);
        if (f_sets(s) == 6'd0) return "R10";
        if (s >= 4'd8) return "R3";
        return "R2";
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // advance one clock; compare outputs against the reference model
    task automatic step(input string tag);
        bit [2:0] t, f1, f2;
        bit two, h1, h2, nt, na;
        t   = {pc_valid && (pc == pc_ref),
               f_addr(a0_mode, a0_lo, a0_hi, a0_den, a0_dval, a0_dmask),
               f_addr(a1_mode, a1_lo, a1_hi, a1_den, a1_dval, a1_dmask)};
        f1  = f_sets(cfg_sel)[5:3];
        f2  = f_sets(cfg_sel)[2:0];
        two = (cfg_sel >= 4'd8) && (f1 != 3'd0);
        h1  = |(f1 & t);
        h2  = |(f2 & t);
        nt  = 1'b0;
        na  = m_armed;
        if (rst || rearm || cfg_wr || f1 == 3'd0) na = 1'b0;
        else if (!two) begin nt = h1; na = 1'b0; end
        else if (m_armed) begin if (h2) begin nt = 1'b1; na = 1'b0; end end
        else if (h1) na = 1'b1;
        m_trig  = nt;
        m_armed = na;
        @(posedge clk);
        #1;
        chk(trig, m_trig, tag, "trig");
        chk(armed, m_armed, tag, "armed");
    endtask

    task automatic idle();
        pc_valid  = 1'b0;
        bus_valid = 1'b0;
        rearm     = 1'b0;
        cfg_wr    = 1'b0;
    endtask

    task automatic write_cfg(input logic [3:0] s);
        idle();
        cfg_sel = s;
        cfg_wr  = 1'b1;
        step("R11");
        cfg_wr  = 1'b0;
    endtask

    task automatic bus(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        idle();
        bus_valid = 1'b1;
        bus_addr  = a;
        bus_data  = d;
        step(tag);
        bus_valid = 1'b0;
    endtask

    task automatic pcev(input logic [AW-1:0] a, input string tag);
        idle();
        pc_valid = 1'b1;
        pc       = a;
        step(tag);
        pc_valid = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; idle();
        cfg_sel = 4'd0; pc_ref = 32'h40; pc = 32'h0;
        a0_mode = 2'd0; a0_lo = '0; a0_hi = '0; a0_den = 1'b0; a0_dval = '0; a0_dmask = '0;
        a1_mode = 2'd0; a1_lo = '0; a1_hi = '0; a1_den = 1'b0; a1_dval = '0; a1_dmask = '0;
        bus_addr = '0; bus_data = '0;
        step("R1");
        step("R1");
        chk(trig, 1'b0, "R1", "trig after reset");
        chk(armed, 1'b0, "R1", "armed after reset");
        rst = 1'b0;

        // R6 equal mode on comparator 0
        a0_mode = 2'd1; a0_lo = 32'h100;
        write_cfg(4'd4);
        bus(32'h100, 32'h0, "R6"); chk(trig, 1'b1, "R6", "equal hit");
        bus(32'h104, 32'h0, "R6"); chk(trig, 1'b0, "R6", "equal miss");

        // R5 inclusive range on comparator 1
        a1_mode = 2'd2; a1_lo = 32'h200; a1_hi = 32'h210;
        write_cfg(4'd6);
        bus(32'h200, 32'h0, "R5"); chk(trig, 1'b1, "R5", "low bound");
        bus(32'h210, 32'h0, "R5"); chk(trig, 1'b1, "R5", "high bound");
        bus(32'h211, 32'h0, "R5"); chk(trig, 1'b0, "R5", "above");
        bus(32'h1FF, 32'h0, "R5"); chk(trig, 1'b0, "R5", "below");

        // R7 outside range
        a1_mode = 2'd3;
        write_cfg(4'd6);
        bus(32'h1FF, 32'h0, "R7"); chk(trig, 1'b1, "R7", "below lo");
        bus(32'h200, 32'h0, "R7"); chk(trig, 1'b0, "R7", "on lo");
        bus(32'h210, 32'h0, "R7"); chk(trig, 1'b0, "R7", "on hi");
        bus(32'h211, 32'h0, "R7"); chk(trig, 1'b1, "R7", "above hi");

        // R8 valid strobe and disabled mode
        write_cfg(4'd4);
        idle(); bus_addr = 32'h100; step("R8"); chk(trig, 1'b0, "R8", "no bus_valid");
        a0_mode = 2'd0;
        write_cfg(4'd4);
        bus(32'h100, 32'h0, "R8"); chk(trig, 1'b0, "R8", "mode off");
        write_cfg(4'd1);
        idle(); pc = 32'h40; step("R8"); chk(trig, 1'b0, "R8", "no pc_valid");
        pcev(32'h40, "R2"); chk(trig, 1'b1, "R2", "pc hit");

        // R9 masked data qualifier
        a0_mode = 2'd1; a0_den = 1'b1; a0_dval = 32'hAB; a0_dmask = 32'h0F;
        write_cfg(4'd2);
        bus(32'h100, 32'hA5, "R9"); chk(trig, 1'b1, "R9", "masked nibble");
        bus(32'h100, 32'hB5, "R9"); chk(trig, 1'b0, "R9", "data mismatch");
        a0_den = 1'b0;

        // R3 ordering: A0 then PC
        write_cfg(4'd13);
        pcev(32'h40, "R3"); chk(armed, 1'b0, "R3", "pc first no arm");
        bus(32'h100, 32'h0, "R3"); chk(armed, 1'b1, "R3", "a0 arms");
        chk(trig, 1'b0, "R3", "no fire on arm");
        pcev(32'h40, "R3"); chk(trig, 1'b1, "R3", "pc fires");
        chk(armed, 1'b0, "R3", "disarm on fire");
        idle(); step("R3"); chk(trig, 1'b0, "R3", "single pulse");

        // R4 both levels in one cycle: arm only
        write_cfg(4'd8);
        idle(); pc_valid = 1'b1; pc = 32'h40; bus_valid = 1'b1; bus_addr = 32'h100;
        step("R4"); chk(armed, 1'b1, "R4", "armed"); chk(trig, 1'b0, "R4", "no fire");
        bus(32'h100, 32'h0, "R4"); chk(trig, 1'b1, "R4", "later fire");

        // R11 rearm clears and blocks firing
        pcev(32'h40, "R11"); chk(armed, 1'b1, "R11", "armed again");
        idle(); rearm = 1'b1; bus_valid = 1'b1; bus_addr = 32'h100;
        step("R11"); chk(armed, 1'b0, "R11", "rearm clears"); chk(trig, 1'b0, "R11", "no fire");

        // R10 illegal codes
        cfg_sel = 4'd7;
        idle(); pc_valid = 1'b1; bus_valid = 1'b1;
        step("R10"); chk(trig, 1'b0, "R10", "code 7"); chk(armed, 1'b0, "R10", "code 7 arm");
        cfg_sel = 4'd15; step("R10"); chk(trig, 1'b0, "R10", "code 15");

        // random streams
        for (int i = 0; i < 4000; i++) begin
            idle();
            if (($urandom % 40) == 0) begin
                cfg_sel  = 4'($urandom);
                a0_mode  = 2'($urandom); a1_mode = 2'($urandom);
                a0_lo    = 32'($urandom % 12); a0_hi = a0_lo + 32'($urandom % 8);
                a1_lo    = 32'($urandom % 12); a1_hi = a1_lo + 32'($urandom % 8);
                a0_den   = 1'($urandom); a1_den = 1'($urandom);
                a0_dval  = 32'($urandom % 4); a1_dval = 32'($urandom % 4);
                a0_dmask = 32'($urandom % 4); a1_dmask = 32'($urandom % 4);
                pc_ref   = 32'($urandom % 6);
                cfg_wr   = 1'b1;
            end
            rearm     = (($urandom % 30) == 0);
            pc_valid  = 1'($urandom);
            pc        = 32'($urandom % 6);
            bus_valid = 1'($urandom);
            bus_addr  = 32'($urandom % 24);
            bus_data  = 32'($urandom % 4);
            step(f_tag(cfg_sel));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule